// File: doc/BRIEF.md
# Lockable Protection Control Register

This block is the control register of a memory-protection unit's code-encapsulation feature. It holds three control bits: a lock, an enable and a violation-route select. It also holds a set of segment-boundary registers, 16 bits each. It sits on a simple register bus with a one-cycle registered read path.

Writes to the control word need all of the following: a full-word strobe, a valid password indication, and the lock bit still clear. Once software sets the lock, the control bits and the boundary registers cannot be changed. Only a brown-out reset, which is the block's `rst` input, releases the lock.

A neighbouring comparator reports an illegal access to the encapsulated segment with a one-cycle strobe. While the enable bit is set, this block turns that strobe into a sticky violation flag. It also issues one of two single-cycle requests. If the select bit is clear, it issues a non-maskable interrupt request, and only when the segment interrupt enable is high. If the select bit is set, it issues a system reset request.

Top module: `ipe_guard_ctrl`

## Requirements
- R1: After a brown-out reset, the following are all 0: the control bits, every boundary register, the violation flag, both request outputs and the read data.
- R2: The bus addresses and layouts are as follows.
  - Address 0 reads the control word: lock at bit 7, enable at bit 6, select at bit 5. All other bits read 0.
  - Address 1 reads boundary register 0 and address 2 reads boundary register 1.
  - Address 3 returns the violation flag in bit 0, with all other bits 0.
  - Read data appears on the cycle after the address is presented.
- R3: A write to address 0 takes effect only if it is a word write (`bus_word`=1) with `pw_ok`=1 and the lock clear. Byte writes and writes without the password leave every control bit unchanged.
- R4: The lock bit is sticky. Once it is 1, only `rst` clears it. `warm_rst` and any bus write leave it at 1.
- R5: While the lock is 1, the enable and select bits and all boundary registers keep their values whatever is written.
- R6: A boundary register takes a word write to its address while the lock is 0, with no password needed. A byte write leaves it unchanged.
- R7: With enable=1 and select=0, a violation strobe sets the flag on the next cycle. It also pulses `nmi_req` on that cycle if `seg_ie`=1, and `rst_req` stays 0.
- R8: With enable=1 and select=1, a violation strobe sets the flag and pulses `rst_req` on the next cycle. `nmi_req` stays 0 whatever `seg_ie` is.
- R9: While enable=0, violation strobes change neither the flag nor either request.
- R10: The flag stays set until one of `flag_clr`, `warm_rst` or `rst` occurs. A violation in the same cycle as a clear wins, and the flag stays set.
- R11: Each request is a single-cycle pulse, and the two requests are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Brown-out reset, synchronous, active high |
| warm_rst | input | 1 | System reset; clears only the violation flag |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = word-wide write, 0 = byte write |
| bus_wdata | input | 16 | Write data |
| pw_ok | input | 1 | Password valid for this write |
| bus_rdata | output | 16 | Registered read data |
| viol_strobe | input | 1 | Illegal access to encapsulated segment |
| seg_ie | input | 1 | Segment interrupt enable |
| flag_clr | input | 1 | Software clear of the violation flag |
| viol_flag | output | 1 | Pending violation flag |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | Reset request pulse |
| ipe_enabled | output | 1 | Enable bit, to the comparator |
| ipe_locked | output | 1 | Lock bit |
| seg_bounds | output | 32 | Boundary registers, register 0 in the low half |

## Verification
The bench sweeps the following corner cases. Together they expose a design that ignores one of the qualifiers or routes a violation to the wrong output.
- Control writes across every mix of word/byte strobe, password and data pattern. A design that honoured byte writes or missing passwords would show changed enable or select bits on read-back.
- All eight combinations of enable, select and interrupt enable under a violation strobe. A design that swapped the routes would raise an interrupt where a reset is due, or stretch a pulse past one cycle.
- A violation in the same cycle as a flag clear. A design that let the clear win would lose the pending flag.
- Writes to every register after the lock is set, then a warm reset, then a brown-out. A lock that is not sticky, or that is cleared by the warm reset, would let frozen values move.

// File: rtl/ipe_guard_pkg.sv
package ipe_guard_pkg;

  // Control bits as held in the register, independent of bus position
  typedef struct packed {
    logic lock;
    logic ena;
    logic vsel;
  } ipe_ctl_t;

  localparam int unsigned CTL_BITS = 3;

endpackage

// File: rtl/ipe_ctl_reg.sv
module ipe_ctl_reg
  import ipe_guard_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_hit,
  input  logic     is_word,
  input  logic     pw_ok,
  input  ipe_ctl_t wbits,
  output ipe_ctl_t ctl_q
);

  logic accept;

  // A write lands only when word-wide, password-qualified and unlocked
  assign accept = wr_hit && is_word && pw_ok && !ctl_q.lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (accept) begin
      ctl_q.lock <= ctl_q.lock | wbits.lock;
      ctl_q.ena  <= wbits.ena;
      ctl_q.vsel <= wbits.vsel;
    end
  end

endmodule

// File: rtl/ipe_bound_regs.sv
module ipe_bound_regs #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_BOUNDS = 2,
  parameter int unsigned BASE_ADDR  = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr,
  input  logic                               is_word,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic                               locked,
  output logic [NUM_BOUNDS-1:0][DATA_W-1:0]  bounds_q
);

  for (genvar i = 0; i < NUM_BOUNDS; i++) begin : g_bound
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + i);
    logic take;

    assign take = wr && is_word && !locked && (addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (rst) begin
        bounds_q[i] <= '0;
      end else if (take) begin
        bounds_q[i] <= wdata;
      end
    end
  end

endmodule

// File: rtl/ipe_viol_ctrl.sv
module ipe_viol_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic warm_rst,
  input  logic viol_strobe,
  input  logic ena,
  input  logic vsel,
  input  logic seg_ie,
  input  logic flag_clr,
  output logic flag_q,
  output logic nmi_q,
  output logic rreq_q
);

  logic hit;

  assign hit = viol_strobe && ena;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      nmi_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      // Requests are one-cycle pulses by default
      nmi_q  <= 1'b0;
      rreq_q <= 1'b0;
      if (hit) begin
        flag_q <= 1'b1;
        if (vsel) begin
          rreq_q <= 1'b1;
        end else begin
          nmi_q  <= seg_ie;
        end
      end else if (flag_clr || warm_rst) begin
        flag_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ipe_rd_mux.sv
module ipe_rd_mux
  import ipe_guard_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_BOUNDS = 2,
  parameter int unsigned BASE_ADDR  = 1,
  parameter int unsigned STAT_ADDR  = 3,
  parameter int unsigned LOCK_POS   = 7,
  parameter int unsigned ENA_POS    = 6,
  parameter int unsigned VS_POS     = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ADDR_W-1:0]                 addr,
  input  ipe_ctl_t                          ctl,
  input  logic [NUM_BOUNDS-1:0][DATA_W-1:0] bounds,
  input  logic                              flag,
  output logic [DATA_W-1:0]                 rdata_q
);

  localparam logic [ADDR_W-1:0] CTL_A  = '0;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == CTL_A) begin
      rd_next[LOCK_POS] = ctl.lock;
      rd_next[ENA_POS]  = ctl.ena;
      rd_next[VS_POS]   = ctl.vsel;
    end
    for (int i = 0; i < NUM_BOUNDS; i++) begin
      if (addr == ADDR_W'(BASE_ADDR + i)) begin
        rd_next = bounds[i];
      end
    end
    if (addr == STAT_A) begin
      rd_next[0] = flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_next;
    end
  end

endmodule

// File: rtl/ipe_guard_ctrl.sv
module ipe_guard_ctrl
  import ipe_guard_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_BOUNDS = 2,
  parameter int unsigned LOCK_POS   = 7,
  parameter int unsigned ENA_POS    = 6,
  parameter int unsigned VS_POS     = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         warm_rst,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_word,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic                         pw_ok,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         viol_strobe,
  input  logic                         seg_ie,
  input  logic                         flag_clr,
  output logic                         viol_flag,
  output logic                         nmi_req,
  output logic                         rst_req,
  output logic                         ipe_enabled,
  output logic                         ipe_locked,
  output logic [NUM_BOUNDS*DATA_W-1:0] seg_bounds
);

  localparam int unsigned BOUND_BASE = 1;
  localparam int unsigned STAT_ADDR  = BOUND_BASE + NUM_BOUNDS;
  localparam logic [ADDR_W-1:0] CTL_A = '0;

  ipe_ctl_t                          ctl_q;
  ipe_ctl_t                          ctl_wbits;
  logic [NUM_BOUNDS-1:0][DATA_W-1:0] bounds_q;
  logic                              ctl_hit;
  logic                              vsel_w;

  assign ctl_hit        = bus_wr && (bus_addr == CTL_A);
  assign ctl_wbits.lock = bus_wdata[LOCK_POS];
  assign ctl_wbits.ena  = bus_wdata[ENA_POS];
  assign ctl_wbits.vsel = bus_wdata[VS_POS];

  ipe_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (ctl_hit),
    .is_word (bus_word),
    .pw_ok   (pw_ok),
    .wbits   (ctl_wbits),
    .ctl_q   (ctl_q)
  );

  ipe_bound_regs #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_BOUNDS (NUM_BOUNDS),
    .BASE_ADDR  (BOUND_BASE)
  ) u_bounds (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .is_word  (bus_word),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .locked   (ctl_q.lock),
    .bounds_q (bounds_q)
  );

  ipe_viol_ctrl u_viol (
    .clk         (clk),
    .rst         (rst),
    .warm_rst    (warm_rst),
    .viol_strobe (viol_strobe),
    .ena         (ctl_q.ena),
    .vsel        (ctl_q.vsel),
    .seg_ie      (seg_ie),
    .flag_clr    (flag_clr),
    .flag_q      (viol_flag),
    .nmi_q       (nmi_req),
    .rreq_q      (rst_req)
  );

  ipe_rd_mux #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_BOUNDS (NUM_BOUNDS),
    .BASE_ADDR  (BOUND_BASE),
    .STAT_ADDR  (STAT_ADDR),
    .LOCK_POS   (LOCK_POS),
    .ENA_POS    (ENA_POS),
    .VS_POS     (VS_POS)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .ctl     (ctl_q),
    .bounds  (bounds_q),
    .flag    (viol_flag),
    .rdata_q (bus_rdata)
  );

  assign ipe_enabled = ctl_q.ena;
  assign ipe_locked  = ctl_q.lock;
  assign vsel_w      = ctl_q.vsel;
  assign seg_bounds  = bounds_q;

endmodule

// File: rtl/ipe_guard_chk.sv
module ipe_guard_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned NUM_BOUNDS = 2,
  parameter int unsigned LOCK_POS   = 7,
  parameter int unsigned ENA_POS    = 6,
  parameter int unsigned VS_POS     = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_wr,
  input logic                         bus_word,
  input logic                         pw_ok,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic                         viol_strobe,
  input logic                         seg_ie,
  input logic                         viol_flag,
  input logic                         nmi_req,
  input logic                         rst_req,
  input logic                         ipe_enabled,
  input logic                         ipe_locked,
  input logic                         vsel,
  input logic [NUM_BOUNDS*DATA_W-1:0] seg_bounds
);

  localparam logic [DATA_W-1:0] CTL_MASK =
    (DATA_W'(1) << LOCK_POS) | (DATA_W'(1) << ENA_POS) | (DATA_W'(1) << VS_POS);
  localparam logic [DATA_W-1:0] RSV_MASK = ~CTL_MASK;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == '0) |-> ((bus_rdata & RSV_MASK) == '0));

  assert_byte_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_word) |=> $stable({ipe_locked, ipe_enabled, vsel, seg_bounds}));

  assert_nopw_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == '0 && !pw_ok) |=> $stable({ipe_locked, ipe_enabled, vsel}));

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    ipe_locked |=> ipe_locked);

  assert_ctl_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    ipe_locked |=> $stable({ipe_enabled, vsel}));

  assert_bounds_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    ipe_locked |=> $stable(seg_bounds));

  assert_nmi_cause_R7: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> $past(viol_strobe && ipe_enabled && !vsel && seg_ie));

  assert_rst_cause_R8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(viol_strobe && ipe_enabled && vsel));

  assert_viol_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (viol_strobe && !ipe_enabled) |=> (!nmi_req && !rst_req));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    (viol_strobe && ipe_enabled) |=> viol_flag);

  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(nmi_req && rst_req));

endmodule

bind ipe_guard_ctrl ipe_guard_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .NUM_BOUNDS (NUM_BOUNDS),
  .LOCK_POS   (LOCK_POS),
  .ENA_POS    (ENA_POS),
  .VS_POS     (VS_POS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_word    (bus_word),
  .pw_ok       (pw_ok),
  .bus_rdata   (bus_rdata),
  .viol_strobe (viol_strobe),
  .seg_ie      (seg_ie),
  .viol_flag   (viol_flag),
  .nmi_req     (nmi_req),
  .rst_req     (rst_req),
  .ipe_enabled (ipe_enabled),
  .ipe_locked  (ipe_locked),
  .vsel        (vsel_w),
  .seg_bounds  (seg_bounds)
);

// File: tb/sim_ipe_guard_ctrl.sv
module sim_ipe_guard_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        pw_ok = 1'b0;
  logic [15:0] bus_rdata;
  logic        viol_strobe = 1'b0;
  logic        seg_ie = 1'b0;
  logic        flag_clr = 1'b0;
  logic        viol_flag, nmi_req, rst_req, ipe_enabled, ipe_locked;
  logic [31:0] seg_bounds;

  int total = 0;
  int bad = 0;
  logic       m_lock, m_ena, m_vs;
  logic [15:0] m_b [2];

  always #5 clk = ~clk;

  ipe_guard_ctrl u0 (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .pw_ok(pw_ok), .bus_rdata(bus_rdata), .viol_strobe(viol_strobe),
    .seg_ie(seg_ie), .flag_clr(flag_clr), .viol_flag(viol_flag),
    .nmi_req(nmi_req), .rst_req(rst_req), .ipe_enabled(ipe_enabled),
    .ipe_locked(ipe_locked), .seg_bounds(seg_bounds)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lock = 0; m_ena = 0; m_vs = 0; m_b[0] = '0; m_b[1] = '0;
  endtask

  task automatic bor();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic word, input logic pw);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; pw_ok = pw; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pw_ok = 1'b0;
    if (a == 2'd0 && word && pw && !m_lock) begin
      m_lock = d[7]; m_ena = d[6]; m_vs = d[5];
    end
    if ((a == 2'd1 || a == 2'd2) && word && !m_lock) m_b[a-1] = d;
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {8'h00, m_lock, m_ena, m_vs, 5'b0};
      2'd1: return m_b[0];
      2'd2: return m_b[1];
      default: return {15'b0, viol_flag};
    endcase
  endfunction

  task automatic rd_chk(input string req, input logic [1:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk);
    chk(req, {16'h0, bus_rdata}, {16'h0, exp_rd(a)});
  endtask

  // Strobe a violation and check the cycle after plus the one after that
  task automatic viol_chk(input string req, input logic exp_flag, input logic exp_nmi, input logic exp_rr);
    @(negedge clk); viol_strobe = 1'b1;
    @(negedge clk); viol_strobe = 1'b0;
    chk({req, " flag"}, {31'b0, viol_flag}, {31'b0, exp_flag});
    chk({req, " nmi"},  {31'b0, nmi_req},  {31'b0, exp_nmi});
    chk({req, " rreq"}, {31'b0, rst_req},  {31'b0, exp_rr});
    @(negedge clk);
    chk("R11 nmi single pulse", {31'b0, nmi_req}, 32'd0);
    chk("R11 rreq single pulse", {31'b0, rst_req}, 32'd0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 flag", {31'b0, viol_flag}, 32'd0);
    chk("R1 reqs", {30'b0, nmi_req, rst_req}, 32'd0);
    chk("R1 ctl", {30'b0, ipe_locked, ipe_enabled}, 32'd0);
    chk("R1 bounds", seg_bounds, 32'd0);
    chk("R1 rdata", {16'h0, bus_rdata}, 32'd0);
    for (int a = 0; a < 4; a++) rd_chk("R1 R2 read after reset", 2'(a));

    // R2 R3: sweep control writes over strobe width, password and bit pattern
    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 2; p++)
        for (int pat = 0; pat < 4; pat++) begin
          wr(2'd0, 16'hFF1F | 16'(pat << 5), w[0], p[0]);
          rd_chk("R2 R3 ctl write sweep", 2'd0);
          chk("R3 enable port", {31'b0, ipe_enabled}, {31'b0, m_ena});
        end

    // R6: boundary registers, word and byte
    for (int a = 1; a < 3; a++)
      for (int k = 0; k < 3; k++) begin
        wr(2'(a), 16'(16'h1357 * (k + a)), k[0] ? 1'b0 : 1'b1, 1'b0);
        rd_chk("R6 bound write", 2'(a));
      end
    chk("R6 bound port", seg_bounds, {m_b[1], m_b[0]});

    // R7 R8 R9: every combination of enable, select, interrupt enable
    for (int c = 0; c < 8; c++) begin
      logic e, v, ie;
      e = c[2]; v = c[1]; ie = c[0];
      wr(2'd0, {8'h00, 1'b0, e, v, 5'b0}, 1'b1, 1'b1);
      seg_ie = ie;
      if (!e)      viol_chk("R9 disabled", 1'b0, 1'b0, 1'b0);
      else if (v)  viol_chk("R8 reset route", 1'b1, 1'b0, 1'b1);
      else         viol_chk("R7 nmi route", 1'b1, ie, 1'b0);
      rd_chk("R10 flag read", 2'd3);
      @(negedge clk);
      if (c[0]) warm_rst = 1'b1; else flag_clr = 1'b1;
      @(negedge clk); warm_rst = 1'b0; flag_clr = 1'b0;
      chk("R10 flag cleared", {31'b0, viol_flag}, 32'd0);
    end

    // R10: flag holds, and a violation beats a simultaneous clear
    wr(2'd0, 16'h0040, 1'b1, 1'b1);
    seg_ie = 1'b0;
    viol_chk("R7 no ie", 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 flag held", {31'b0, viol_flag}, 32'd1);
    @(negedge clk); viol_strobe = 1'b1; flag_clr = 1'b1;
    @(negedge clk); viol_strobe = 1'b0; flag_clr = 1'b0;
    chk("R10 set wins over clear", {31'b0, viol_flag}, 32'd1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R10 clear", {31'b0, viol_flag}, 32'd0);

    // R4 R5: lock then try to change everything
    wr(2'd1, 16'hA5A5, 1'b1, 1'b0);
    wr(2'd2, 16'h5A5A, 1'b1, 1'b0);
    wr(2'd0, 16'h00C0, 1'b1, 1'b1);
    chk("R4 locked", {31'b0, ipe_locked}, 32'd1);
    wr(2'd0, 16'h0020, 1'b1, 1'b1);
    rd_chk("R5 ctl frozen", 2'd0);
    chk("R5 enable kept", {31'b0, ipe_enabled}, 32'd1);
    wr(2'd1, 16'h1111, 1'b1, 1'b0);
    wr(2'd2, 16'h2222, 1'b1, 1'b1);
    rd_chk("R5 bound0 frozen", 2'd1);
    rd_chk("R5 bound1 frozen", 2'd2);
    chk("R5 bounds port", seg_bounds, 32'h5A5AA5A5);
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    chk("R4 warm reset keeps lock", {31'b0, ipe_locked}, 32'd1);
    bor();
    chk("R4 R1 brown-out clears lock", {31'b0, ipe_locked}, 32'd0);
    chk("R1 bounds after brown-out", seg_bounds, 32'd0);
    rd_chk("R1 ctl after brown-out", 2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule